// File: doc/BRIEF.md
# Interrupt Controller Register Interface and Command Decoder

This block is the programming front end of one eight-line interrupt controller. A host reaches it through byte-wide, single-cycle read and write strobes at two register addresses, plus a separate select for the edge/level trigger register. The block steps through the multi-word setup sequence, holds the line mask, the vector base and the mode flags, and turns command bytes into end-of-interrupt and priority-rotation actions.

The request register, the in-service register and the priority resolver live in neighbouring blocks. This block reads their state through its inputs: the highest in-service line and the highest pending line. It acts on them through one-cycle clear strobes for in-service and request bits. It also raises a one-cycle quiet pulse that tells the output stage to drop the interrupt line while setup is restarting. One parameter sets which trigger bits are writable, so the same block serves as the primary or the cascaded controller.

Top module: `irqc_regif`

## Requirements
- R1: After reset the mask, vector base, trigger register, priority base and all mode flags (nested, auto-EOI, rotate-on-auto-EOI, special mask, read select, poll) are zero, and every strobe output is zero.
- R2: A register write at address 0 with bit 4 set restarts setup. In that cycle it raises the quiet pulse and drives both clear strobes to all ones. From the next cycle the mask, vector base, priority base and all mode flags read zero.
- R3: After a restart, address-1 writes are consumed in order. The first stores bits 7:3 as the vector base. The second ends setup, unless bit 0 of the restart byte was set, in which case a third write is consumed that loads the nested flag from bit 4 and the auto-EOI flag from bit 1. The mask is untouched by these setup words.
- R4: An address-1 write outside the setup sequence loads the mask register with the whole byte.
- R5: An address-0 write with bit 4 clear and bit 3 set is a mode byte. Bit 2 arms poll. Read select takes bit 0 only when bit 1 is set. The special-mask flag takes bit 5 only when bit 6 is set.
- R6: An address-0 write with bits 4 and 3 clear carries an operation code in bits 7:5. Code 0 clears the rotate-on-auto-EOI flag and code 4 sets it.
- R7: Codes 1 and 5 clear the in-service bit of the highest-priority in-service line, which comes from the resolver. Code 5 also sets the priority base to that line plus one, modulo 8. With no in-service line reported, neither code has any effect.
- R8: Code 3 clears the in-service bit chosen by bits 2:0. Code 7 does the same and also sets the priority base to that line plus one, modulo 8. Code 6 sets the priority base to bits 2:0 plus one, modulo 8, without clearing anything. Code 2 has no effect.
- R9: Without poll armed, reading address 0 returns the in-service register when read select is 1 and the request register when it is 0. Reading address 1 returns the mask.
- R10: A register read while poll is armed returns the pending line number, or 7 when nothing is pending. When a line is pending, the read pulses that line's request and in-service clear bits. The read disarms poll.
- R11: A trigger-register write stores the byte ANDed with the parameter TRIG_WMASK, and a trigger-register read returns it. A setup restart leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_addr | input | 1 | Register address (0 or 1) |
| bus_trig_sel | input | 1 | Access targets the trigger register instead |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high |
| req_lines | input | 8 | Current request register |
| svc_lines | input | 8 | Current in-service register |
| svc_top_vld | input | 1 | Some in-service bit is set |
| svc_top_line | input | 3 | Highest-priority in-service line |
| pend_vld | input | 1 | An unmasked request outranks service |
| pend_line | input | 3 | Highest-priority pending line |
| mask_o | output | 8 | Line mask register |
| vec_base_o | output | 5 | Vector base (upper five bits) |
| nested_o | output | 1 | Special fully nested flag |
| auto_eoi_o | output | 1 | Automatic end-of-interrupt flag |
| rot_aeoi_o | output | 1 | Rotate on automatic end-of-interrupt |
| spec_mask_o | output | 1 | Special mask flag |
| prio_base_o | output | 3 | Line holding lowest priority plus one |
| trig_mode_o | output | 8 | Edge/level trigger register |
| svc_clr_o | output | 8 | In-service clear strobe |
| req_clr_o | output | 8 | Request clear strobe |
| out_quiet_o | output | 1 | Drop the interrupt output this cycle |

## Verification
The bench builds two copies of the block. One keeps the default TRIG_WMASK of 8'hF8, and the other uses 8'hDE. The same all-ones trigger write therefore shows both writable-bit patterns. With both copies, masking of low and middle bits is checked and not only the default pattern. The other cases are all reached on the default copy: every operation code, the base wrapping from line 7 back to 0, and setup sequences with and without the fourth word.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  typedef enum logic [1:0] {
    INIT_IDLE      = 2'd0,
    INIT_WAIT_BASE = 2'd1,
    INIT_WAIT_CASC = 2'd2,
    INIT_WAIT_MODE = 2'd3
  } init_stage_e;

  typedef enum logic [2:0] {
    OP_ROT_CLR  = 3'd0,
    OP_EOI      = 3'd1,
    OP_NOP      = 3'd2,
    OP_SEOI     = 3'd3,
    OP_ROT_SET  = 3'd4,
    OP_EOI_ROT  = 3'd5,
    OP_SET_BASE = 3'd6,
    OP_SEOI_ROT = 3'd7
  } op_code_e;

endpackage

// File: rtl/irqc_init_fsm.sv
module irqc_init_fsm
  import irqc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LINE_W = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     init_hit,
  input  logic                     cfg_hit,
  input  logic [DATA_W-1:0]        wdata,
  output logic [DATA_W-1:0]        mask_o,
  output logic [DATA_W-LINE_W-1:0] vec_base_o,
  output logic                     nested_o,
  output logic                     auto_eoi_o,
  output init_stage_e              stage_o
);

  localparam int VB_W = DATA_W - LINE_W;

  logic need_mode;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_o    <= INIT_IDLE;
      need_mode  <= 1'b0;
      mask_o     <= '0;
      vec_base_o <= '0;
      nested_o   <= 1'b0;
      auto_eoi_o <= 1'b0;
    end else if (init_hit) begin
      stage_o    <= INIT_WAIT_BASE;
      need_mode  <= wdata[0];
      mask_o     <= '0;
      vec_base_o <= '0;
      nested_o   <= 1'b0;
      auto_eoi_o <= 1'b0;
    end else if (cfg_hit) begin
      unique case (stage_o)
        INIT_IDLE: mask_o <= wdata;
        INIT_WAIT_BASE: begin
          vec_base_o <= wdata[DATA_W-1 -: VB_W];
          stage_o    <= INIT_WAIT_CASC;
        end
        INIT_WAIT_CASC: stage_o <= need_mode ? INIT_WAIT_MODE : INIT_IDLE;
        INIT_WAIT_MODE: begin
          nested_o   <= wdata[4];
          auto_eoi_o <= wdata[1];
          stage_o    <= INIT_IDLE;
        end
        default: stage_o <= INIT_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/irqc_op_cmd.sv
module irqc_op_cmd
  import irqc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LINE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_hit,
  input  logic              mode_hit,
  input  logic              cmd_hit,
  input  logic              poll_take,
  input  logic [DATA_W-1:0] wdata,
  input  logic              svc_top_vld,
  input  logic [LINE_W-1:0] svc_top_line,
  output logic              rot_aeoi_o,
  output logic [LINE_W-1:0] prio_base_o,
  output logic              read_isr_o,
  output logic              poll_armed_o,
  output logic              spec_mask_o,
  output logic [DATA_W-1:0] eoi_clr_o
);

  function automatic logic [LINE_W-1:0] succ_line(input logic [LINE_W-1:0] l);
    return l + LINE_W'(1);
  endfunction

  function automatic logic [DATA_W-1:0] line_bit(input logic [LINE_W-1:0] l);
    return DATA_W'(1) << l;
  endfunction

  op_code_e          op;
  logic [LINE_W-1:0] arg_line;
  logic              base_ld;
  logic [LINE_W-1:0] base_nxt;

  assign op       = op_code_e'(wdata[DATA_W-1 -: 3]);
  assign arg_line = wdata[LINE_W-1:0];

  always_comb begin
    eoi_clr_o = '0;
    base_ld   = 1'b0;
    base_nxt  = prio_base_o;
    if (cmd_hit) begin
      unique case (op)
        OP_EOI, OP_EOI_ROT: begin
          if (svc_top_vld) begin
            eoi_clr_o = line_bit(svc_top_line);
            if (op == OP_EOI_ROT) begin
              base_ld  = 1'b1;
              base_nxt = succ_line(svc_top_line);
            end
          end
        end
        OP_SEOI: eoi_clr_o = line_bit(arg_line);
        OP_SEOI_ROT: begin
          eoi_clr_o = line_bit(arg_line);
          base_ld   = 1'b1;
          base_nxt  = succ_line(arg_line);
        end
        OP_SET_BASE: begin
          base_ld  = 1'b1;
          base_nxt = succ_line(arg_line);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || init_hit) begin
      rot_aeoi_o   <= 1'b0;
      prio_base_o  <= '0;
      read_isr_o   <= 1'b0;
      poll_armed_o <= 1'b0;
      spec_mask_o  <= 1'b0;
    end else begin
      if (poll_take) poll_armed_o <= 1'b0;
      if (mode_hit) begin
        if (wdata[2]) poll_armed_o <= 1'b1;
        if (wdata[1]) read_isr_o   <= wdata[0];
        if (wdata[6]) spec_mask_o  <= wdata[5];
      end
      if (cmd_hit && op == OP_ROT_CLR) rot_aeoi_o <= 1'b0;
      if (cmd_hit && op == OP_ROT_SET) rot_aeoi_o <= 1'b1;
      if (base_ld) prio_base_o <= base_nxt;
    end
  end

endmodule

// File: rtl/irqc_read_mux.sv
module irqc_read_mux #(
  parameter int DATA_W = 8,
  parameter int LINE_W = 3
) (
  input  logic              poll_armed,
  input  logic              addr,
  input  logic              trig_sel,
  input  logic              read_isr,
  input  logic [DATA_W-1:0] req_lines,
  input  logic [DATA_W-1:0] svc_lines,
  input  logic [DATA_W-1:0] mask,
  input  logic [DATA_W-1:0] trig,
  input  logic              pend_vld,
  input  logic [LINE_W-1:0] pend_line,
  output logic [DATA_W-1:0] rdata
);

  localparam logic [LINE_W-1:0] IDLE_LINE = '1;

  always_comb begin
    if (trig_sel)        rdata = trig;
    else if (poll_armed) rdata = DATA_W'(pend_vld ? pend_line : IDLE_LINE);
    else if (addr)       rdata = mask;
    else if (read_isr)   rdata = svc_lines;
    else                 rdata = req_lines;
  end

endmodule

// File: rtl/irqc_regif.sv
module irqc_regif
  import irqc_pkg::*;
#(
  parameter int          DATA_W    = 8,
  parameter logic [7:0]  TRIG_WMASK = 8'hF8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic        bus_addr,
  input  logic        bus_trig_sel,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  input  logic [7:0]  req_lines,
  input  logic [7:0]  svc_lines,
  input  logic        svc_top_vld,
  input  logic [2:0]  svc_top_line,
  input  logic        pend_vld,
  input  logic [2:0]  pend_line,
  output logic [7:0]  mask_o,
  output logic [4:0]  vec_base_o,
  output logic        nested_o,
  output logic        auto_eoi_o,
  output logic        rot_aeoi_o,
  output logic        spec_mask_o,
  output logic [2:0]  prio_base_o,
  output logic [7:0]  trig_mode_o,
  output logic [7:0]  svc_clr_o,
  output logic [7:0]  req_clr_o,
  output logic        out_quiet_o
);

  localparam int LINE_W = $clog2(DATA_W);

  function automatic logic [DATA_W-1:0] line_bit(input logic [LINE_W-1:0] l);
    return DATA_W'(1) << l;
  endfunction

  logic              reg_acc;
  logic              init_hit;
  logic              mode_hit;
  logic              cmd_hit;
  logic              cfg_hit;
  logic              poll_take;
  logic              poll_armed;
  logic              read_isr;
  logic [DATA_W-1:0] eoi_clr;
  logic [DATA_W-1:0] poll_clr;
  init_stage_e       init_stage;

  assign reg_acc   = !bus_trig_sel;
  assign init_hit  = bus_wr && reg_acc && !bus_addr && bus_wdata[4];
  assign mode_hit  = bus_wr && reg_acc && !bus_addr && !bus_wdata[4] && bus_wdata[3];
  assign cmd_hit   = bus_wr && reg_acc && !bus_addr && !bus_wdata[4] && !bus_wdata[3];
  assign cfg_hit   = bus_wr && reg_acc && bus_addr;
  assign poll_take = bus_rd && reg_acc && poll_armed;
  assign poll_clr  = (poll_take && pend_vld) ? line_bit(pend_line) : '0;

  assign svc_clr_o   = init_hit ? '1 : (eoi_clr | poll_clr);
  assign req_clr_o   = init_hit ? '1 : poll_clr;
  assign out_quiet_o = init_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) trig_mode_o <= '0;
    else if (bus_wr && bus_trig_sel) trig_mode_o <= bus_wdata & TRIG_WMASK;
  end

  irqc_init_fsm #(.DATA_W(DATA_W), .LINE_W(LINE_W)) u_init (
    .clk        (clk),
    .rst_n      (rst_n),
    .init_hit   (init_hit),
    .cfg_hit    (cfg_hit),
    .wdata      (bus_wdata),
    .mask_o     (mask_o),
    .vec_base_o (vec_base_o),
    .nested_o   (nested_o),
    .auto_eoi_o (auto_eoi_o),
    .stage_o    (init_stage)
  );

  irqc_op_cmd #(.DATA_W(DATA_W), .LINE_W(LINE_W)) u_op (
    .clk          (clk),
    .rst_n        (rst_n),
    .init_hit     (init_hit),
    .mode_hit     (mode_hit),
    .cmd_hit      (cmd_hit),
    .poll_take    (poll_take),
    .wdata        (bus_wdata),
    .svc_top_vld  (svc_top_vld),
    .svc_top_line (svc_top_line),
    .rot_aeoi_o   (rot_aeoi_o),
    .prio_base_o  (prio_base_o),
    .read_isr_o   (read_isr),
    .poll_armed_o (poll_armed),
    .spec_mask_o  (spec_mask_o),
    .eoi_clr_o    (eoi_clr)
  );

  irqc_read_mux #(.DATA_W(DATA_W), .LINE_W(LINE_W)) u_rd (
    .poll_armed (poll_armed),
    .addr       (bus_addr),
    .trig_sel   (bus_trig_sel),
    .read_isr   (read_isr),
    .req_lines  (req_lines),
    .svc_lines  (svc_lines),
    .mask       (mask_o),
    .trig       (trig_mode_o),
    .pend_vld   (pend_vld),
    .pend_line  (pend_line),
    .rdata      (bus_rdata)
  );

endmodule

module irqc_regif_chk
  import irqc_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       bus_wr,
  input logic       bus_rd,
  input logic       bus_trig_sel,
  input logic       init_hit,
  input logic       cmd_hit,
  input logic       poll_armed,
  input logic       pend_vld,
  input logic [7:0] mask_o,
  input logic [2:0] prio_base_o,
  input logic [7:0] trig_mode_o,
  input logic [7:0] svc_clr_o,
  input logic [7:0] req_clr_o,
  input init_stage_e init_stage
);

  // R2
  init_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_hit |=> (mask_o == 8'h00 && prio_base_o == 3'd0 && init_stage == INIT_WAIT_BASE));

  // R11
  trig_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_hit |=> $stable(trig_mode_o));

  // R4
  mask_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mask_o) |-> $past(bus_wr && !bus_trig_sel));

  // R7
  eoi_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_hit |-> ($onehot0(svc_clr_o) && req_clr_o == 8'h00));

  // R10
  poll_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_trig_sel && poll_armed && !pend_vld) |-> (svc_clr_o == 8'h00 && req_clr_o == 8'h00));

  // R10
  poll_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_trig_sel && poll_armed && !bus_wr) |=> !poll_armed);

endmodule

bind irqc_regif irqc_regif_chk u_regif_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_wr       (bus_wr),
  .bus_rd       (bus_rd),
  .bus_trig_sel (bus_trig_sel),
  .init_hit     (init_hit),
  .cmd_hit      (cmd_hit),
  .poll_armed   (poll_armed),
  .pend_vld     (pend_vld),
  .mask_o       (mask_o),
  .prio_base_o  (prio_base_o),
  .trig_mode_o  (trig_mode_o),
  .svc_clr_o    (svc_clr_o),
  .req_clr_o    (req_clr_o),
  .init_stage   (init_stage)
);

// File: tb/irqc_regif_bench.sv
module irqc_regif_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0, bus_addr = 1'b0, bus_trig_sel = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] req_lines = 8'h00, svc_lines = 8'h00;
  logic       svc_top_vld = 1'b0, pend_vld = 1'b0;
  logic [2:0] svc_top_line = 3'd0, pend_line = 3'd0;

  logic [7:0] bus_rdata, mask_o, trig_mode_o, svc_clr_o, req_clr_o;
  logic [4:0] vec_base_o;
  logic       nested_o, auto_eoi_o, rot_aeoi_o, spec_mask_o, out_quiet_o;
  logic [2:0] prio_base_o;

  logic       s_wr = 1'b0, s_trig = 1'b0, s_rd = 1'b0;
  logic [7:0] s_rdata, s_mask, s_trig_o, s_sclr, s_rclr;
  logic [4:0] s_vb;
  logic       s_n, s_a, s_r, s_sm, s_q;
  logic [2:0] s_pb;

  int checks = 0;
  int fails  = 0;
  logic [7:0] cap_rd, cap_sclr, cap_rclr;
  logic       cap_q;

  always #10 clk = ~clk;

  irqc_regif u_irqc_regif (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_trig_sel(bus_trig_sel), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .req_lines(req_lines), .svc_lines(svc_lines), .svc_top_vld(svc_top_vld),
    .svc_top_line(svc_top_line), .pend_vld(pend_vld), .pend_line(pend_line),
    .mask_o(mask_o), .vec_base_o(vec_base_o), .nested_o(nested_o), .auto_eoi_o(auto_eoi_o),
    .rot_aeoi_o(rot_aeoi_o), .spec_mask_o(spec_mask_o), .prio_base_o(prio_base_o),
    .trig_mode_o(trig_mode_o), .svc_clr_o(svc_clr_o), .req_clr_o(req_clr_o),
    .out_quiet_o(out_quiet_o)
  );

  irqc_regif #(.TRIG_WMASK(8'hDE)) u_irqc_regif_slv (
    .clk(clk), .rst_n(rst_n), .bus_wr(s_wr), .bus_rd(s_rd), .bus_addr(1'b0),
    .bus_trig_sel(s_trig), .bus_wdata(bus_wdata), .bus_rdata(s_rdata),
    .req_lines(8'h00), .svc_lines(8'h00), .svc_top_vld(1'b0), .svc_top_line(3'd0),
    .pend_vld(1'b0), .pend_line(3'd0), .mask_o(s_mask), .vec_base_o(s_vb),
    .nested_o(s_n), .auto_eoi_o(s_a), .rot_aeoi_o(s_r), .spec_mask_o(s_sm),
    .prio_base_o(s_pb), .trig_mode_o(s_trig_o), .svc_clr_o(s_sclr), .req_clr_o(s_rclr),
    .out_quiet_o(s_q)
  );

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic trig, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_trig_sel = trig; bus_wdata = d;
    #1;
    cap_sclr = svc_clr_o; cap_rclr = req_clr_o; cap_q = out_quiet_o;
    @(negedge clk);
    bus_wr = 1'b0; bus_trig_sel = 1'b0;
  endtask

  task automatic rd(input logic a, input logic trig);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a; bus_trig_sel = trig;
    #1;
    cap_rd = bus_rdata; cap_sclr = svc_clr_o; cap_rclr = req_clr_o;
    @(negedge clk);
    bus_rd = 1'b0; bus_trig_sel = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1", "mask", mask_o, 8'h00);
    chk("R1", "trig", trig_mode_o, 8'h00);
    chk("R1", "flags", {vec_base_o, prio_base_o}, 8'h00);
    chk("R1", "modes", {4'h0, nested_o, auto_eoi_o, rot_aeoi_o, spec_mask_o}, 8'h00);
    chk("R1", "strobes", svc_clr_o | req_clr_o | {7'h0, out_quiet_o}, 8'h00);
    req_lines = 8'hC3;
    rd(1'b0, 1'b0);
    chk("R1", "read select 0 gives requests", cap_rd, 8'hC3);
  endtask

  task automatic t_trig;
    wr(1'b0, 1'b1, 8'hFF);
    @(negedge clk); s_wr = 1'b1; s_trig = 1'b1;
    @(negedge clk); s_wr = 1'b0; s_trig = 1'b0;
    chk("R11", "master trig masked", trig_mode_o, 8'hF8);
    chk("R11", "slave trig masked", s_trig_o, 8'hDE);
    rd(1'b1, 1'b1);
    chk("R11", "trig readback", cap_rd, 8'hF8);
  endtask

  task automatic t_mask_and_init;
    wr(1'b1, 1'b0, 8'h5A);
    chk("R4", "mask load", mask_o, 8'h5A);
    rd(1'b1, 1'b0);
    chk("R9", "addr1 reads mask", cap_rd, 8'h5A);
    wr(1'b0, 1'b0, 8'h80);
    chk("R6", "code 4 sets rotate", {7'h0, rot_aeoi_o}, 8'h01);
    wr(1'b0, 1'b0, 8'hC4);
    chk("R8", "code 6 base", {5'h0, prio_base_o}, 8'h05);
    wr(1'b0, 1'b0, 8'h11);
    chk("R2", "quiet pulse", {7'h0, cap_q}, 8'h01);
    chk("R2", "clear strobes", cap_sclr & cap_rclr, 8'hFF);
    chk("R2", "mask cleared", mask_o, 8'h00);
    chk("R2", "rotate and base cleared", {4'h0, rot_aeoi_o, prio_base_o}, 8'h00);
    chk("R11", "trig kept over restart", trig_mode_o, 8'hF8);
    wr(1'b1, 1'b0, 8'hA5);
    chk("R3", "vector base", {3'h0, vec_base_o}, 8'h14);
    chk("R3", "mask untouched by setup", mask_o, 8'h00);
    wr(1'b1, 1'b0, 8'h04);
    wr(1'b1, 1'b0, 8'h12);
    chk("R3", "nested and auto-EOI", {6'h0, nested_o, auto_eoi_o}, 8'h03);
    chk("R3", "mask still untouched", mask_o, 8'h00);
    wr(1'b1, 1'b0, 8'h33);
    chk("R4", "mask after setup", mask_o, 8'h33);
    wr(1'b0, 1'b0, 8'h10);
    chk("R2", "flags cleared on restart", {6'h0, nested_o, auto_eoi_o}, 8'h00);
    wr(1'b1, 1'b0, 8'h08);
    chk("R3", "vector base short", {3'h0, vec_base_o}, 8'h01);
    wr(1'b1, 1'b0, 8'h00);
    wr(1'b1, 1'b0, 8'h77);
    chk("R3", "three-word setup ends early", mask_o, 8'h77);
    chk("R3", "no mode word consumed", {6'h0, nested_o, auto_eoi_o}, 8'h00);
  endtask

  task automatic t_mode;
    req_lines = 8'h81; svc_lines = 8'h24;
    wr(1'b0, 1'b0, 8'h0B);
    rd(1'b0, 1'b0);
    chk("R5", "read select isr", cap_rd, 8'h24);
    wr(1'b0, 1'b0, 8'h09);
    rd(1'b0, 1'b0);
    chk("R5", "bit1 clear keeps select", cap_rd, 8'h24);
    wr(1'b0, 1'b0, 8'h0A);
    rd(1'b0, 1'b0);
    chk("R9", "read select irr", cap_rd, 8'h81);
    wr(1'b0, 1'b0, 8'h68);
    chk("R5", "special mask set", {7'h0, spec_mask_o}, 8'h01);
    wr(1'b0, 1'b0, 8'h28);
    chk("R5", "bit6 clear keeps special mask", {7'h0, spec_mask_o}, 8'h01);
    wr(1'b0, 1'b0, 8'h48);
    chk("R5", "special mask clear", {7'h0, spec_mask_o}, 8'h00);
    wr(1'b0, 1'b0, 8'h80);
    wr(1'b0, 1'b0, 8'h00);
    chk("R6", "code 0 clears rotate", {7'h0, rot_aeoi_o}, 8'h00);
  endtask

  task automatic t_eoi;
    svc_top_vld = 1'b1; svc_top_line = 3'd5;
    wr(1'b0, 1'b0, 8'h20);
    chk("R7", "code 1 clear", cap_sclr, 8'h20);
    chk("R7", "code 1 base unchanged", {5'h0, prio_base_o}, 8'h00);
    svc_top_line = 3'd6;
    wr(1'b0, 1'b0, 8'hA0);
    chk("R7", "code 5 clear", cap_sclr, 8'h40);
    chk("R7", "code 5 base", {5'h0, prio_base_o}, 8'h07);
    svc_top_line = 3'd7;
    wr(1'b0, 1'b0, 8'hA0);
    chk("R7", "code 5 base wraps", {5'h0, prio_base_o}, 8'h00);
    svc_top_vld = 1'b0; svc_top_line = 3'd2;
    wr(1'b0, 1'b0, 8'hA0);
    chk("R7", "no in-service no clear", cap_sclr, 8'h00);
    chk("R7", "no in-service no base", {5'h0, prio_base_o}, 8'h00);
    wr(1'b0, 1'b0, 8'h63);
    chk("R8", "code 3 clear", cap_sclr, 8'h08);
    chk("R8", "code 3 base kept", {5'h0, prio_base_o}, 8'h00);
    wr(1'b0, 1'b0, 8'hE5);
    chk("R8", "code 7 clear", cap_sclr, 8'h20);
    chk("R8", "code 7 base", {5'h0, prio_base_o}, 8'h06);
    wr(1'b0, 1'b0, 8'hC7);
    chk("R8", "code 6 wraps, no clear", {cap_sclr[4:0], prio_base_o}, 8'h00);
    wr(1'b0, 1'b0, 8'h44);
    chk("R8", "code 2 no clear", cap_sclr, 8'h00);
    chk("R8", "code 2 base kept", {5'h0, prio_base_o}, 8'h00);
  endtask

  task automatic t_poll;
    req_lines = 8'h81; svc_lines = 8'h24;
    pend_vld = 1'b1; pend_line = 3'd3;
    wr(1'b0, 1'b0, 8'h0C);
    rd(1'b1, 1'b0);
    chk("R10", "poll line", cap_rd, 8'h03);
    chk("R10", "poll clears isr", cap_sclr, 8'h08);
    chk("R10", "poll clears irr", cap_rclr, 8'h08);
    rd(1'b1, 1'b0);
    chk("R10", "poll disarmed", cap_rd, 8'h77);
    pend_vld = 1'b0;
    wr(1'b0, 1'b0, 8'h0C);
    rd(1'b0, 1'b0);
    chk("R10", "poll idle value", cap_rd, 8'h07);
    chk("R10", "poll idle no clear", cap_sclr | cap_rclr, 8'h00);
    rd(1'b0, 1'b0);
    chk("R9", "normal read after poll", cap_rd, 8'h81);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_trig();
        t_mask_and_init();
        t_mode();
        t_eoi();
        t_poll();
      end
      begin
        repeat (5000) @(negedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule